// File: doc/BRIEF.md
# Temperature Alert Interrupt Controller

This block turns the result of a remote temperature conversion into a shared, active-low alert line. Each conversion arrives as a one-cycle strobe with a signed two's-complement reading. The block compares the reading with a programmable high limit and records an over-limit event in a sticky status flag. While the alert is not masked, a set flag pulls the alert line low.

Software services the alert through a small register port. Reading the status register returns the flag and clears it. The same read also sets the alert mask, so the shared line is released. An external serial-bus slave can also end the alert. It raises a strobe when this device has answered an alert-response-address query and received an acknowledge. That strobe sets the mask as well. Once the mask is set, the line stays quiet until software writes the mask bit back to zero. This prevents one device from holding the shared line low.

The block tells the bus engine whether it should answer an alert-response query. It does this with a flag that is high whenever its alert is asserted.

Top module: `tai_alert_ctrl`

## Requirements
- R1: `alert_n` is low exactly when the status flag is set and the mask is clear, one clock after those register values. `ara_respond` is always the inverse of `alert_n`.
- R2: On a cycle with `conv_done` high, a signed reading strictly greater than the high limit sets the status flag, which is bit 4 of the status register. A reading equal to the limit does not set it. Without `conv_done` the reading is ignored.
- R3: A read of the status register (address 0x02) returns the flags as they were before the read. The read then clears the flag and sets the mask, and `alert_n` is high afterwards.
- R4: While the mask is set, an over-limit conversion still sets the status flag, but `alert_n` stays high.
- R5: The configuration register is at address 0x09. Bit 7 is the alert mask, and it is the only writable bit. All other bits read as zero.
- R6: An `ara_ack` strobe while `alert_n` is low sets the mask and releases `alert_n`. The status flag is left unchanged.
- R7: Once set, the mask stays set through conversions and `ara_ack` strobes. Only a write of zero to bit 7 clears it.
- R8: An `ara_ack` strobe while `alert_n` is high has no effect on the mask.
- R9: The status flag stays set after later readings fall below the limit, until a status read clears it.
- R10: Reset clears the status flag and the mask, drives `alert_n` high and loads the high limit with 70 (0x46). The high limit is a read/write register at address 0x07.
- R11: If an over-limit conversion and a status read happen in the same cycle, the status flag ends up set. The read still sets the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| conv_done | input | 1 | One-cycle strobe: a new conversion result is on `conv_temp` |
| conv_temp | input | 8 | Signed two's-complement remote reading |
| reg_wr | input | 1 | Register write strobe (takes priority over `reg_rd`) |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ara_ack | input | 1 | Strobe from the bus slave: alert-response reply was acknowledged |
| alert_n | output | 1 | Shared alert line, low when asserted |
| ara_respond | output | 1 | High when this device should answer an alert-response query |

## Verification
The assertions assume that `conv_done`, `reg_rd`, `reg_wr` and `ara_ack` are single-cycle strobes sampled on the rising clock edge. They also assume that register traffic uses one address per cycle. The bench drives every strobe on a falling edge and drops it one cycle later, so each pulse lasts exactly one cycle. It waits a further cycle before it samples `alert_n`, which covers the registered output. The only deliberate overlap is the same-cycle conversion and status read, which the bench places on purpose to exercise the set-over-clear rule.

// File: rtl/tai_pkg.sv
package tai_pkg;

  typedef enum logic [1:0] {
    TAI_SEL_NONE,
    TAI_SEL_STAT,
    TAI_SEL_CFG,
    TAI_SEL_LIM
  } tai_sel_e;

endpackage

// File: rtl/tai_regfile.sv
module tai_regfile
  import tai_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 8'h02,
  parameter logic [ADDR_W-1:0] ADDR_CFG  = 8'h09,
  parameter logic [ADDR_W-1:0] ADDR_LIM  = 8'h07,
  parameter logic [DATA_W-1:0] LIMIT_RST = 8'd70,
  parameter int MASK_BIT  = 7,
  parameter int STAT_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              status_q,
  input  logic              ara_take,
  output logic [DATA_W-1:0] limit_q,
  output logic              mask_q,
  output logic              stat_rd,
  output logic [DATA_W-1:0] reg_rdata
);

  tai_sel_e          sel;
  logic              rd_en;
  logic              cfg_wr;
  logic              lim_wr;
  logic              mask_en;
  logic              mask_d;
  logic [DATA_W-1:0] limit_d;

  // address decode
  always_comb begin
    unique case (reg_addr)
      ADDR_STAT: sel = TAI_SEL_STAT;
      ADDR_CFG:  sel = TAI_SEL_CFG;
      ADDR_LIM:  sel = TAI_SEL_LIM;
      default:   sel = TAI_SEL_NONE;
    endcase
  end

  assign rd_en   = reg_rd & ~reg_wr;
  assign stat_rd = rd_en & (sel == TAI_SEL_STAT);
  assign cfg_wr  = reg_wr & (sel == TAI_SEL_CFG);
  assign lim_wr  = reg_wr & (sel == TAI_SEL_LIM);

  // next state: a software write decides the mask outright, service events only set it
  always_comb begin
    mask_en = cfg_wr | stat_rd | ara_take;
    mask_d  = cfg_wr ? reg_wdata[MASK_BIT] : 1'b1;
    limit_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= 1'b0;
      limit_q <= LIMIT_RST;
    end else begin
      if (mask_en) mask_q  <= mask_d;
      if (lim_wr)  limit_q <= limit_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      TAI_SEL_STAT: reg_rdata[STAT_BIT] = status_q;
      TAI_SEL_CFG:  reg_rdata[MASK_BIT] = mask_q;
      TAI_SEL_LIM:  reg_rdata = limit_q;
      default:      reg_rdata = '0;
    endcase
  end

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !cfg_wr) |=> mask_q); // R7
  AST_STAT_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> mask_q); // R3

endmodule

// File: rtl/tai_detect.sv
module tai_detect #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_temp,
  input  logic [DATA_W-1:0] limit_q,
  input  logic              stat_rd,
  output logic              status_q
);

  logic over;
  logic set_evt;
  logic status_en;
  logic status_d;

  assign over    = $signed(conv_temp) > $signed(limit_q);
  assign set_evt = conv_done & over;

  // a new event outranks the clear from a status read
  always_comb begin
    status_en = set_evt | stat_rd;
    status_d  = set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= 1'b0;
    else if (status_en) status_q <= status_d;
  end

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !stat_rd) |=> status_q); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q && !conv_done) |=> !status_q); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && over && stat_rd) |=> status_q); // R11

endmodule

// File: rtl/tai_alert_drv.sv
module tai_alert_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic status_q,
  input  logic mask_q,
  input  logic ara_ack,
  output logic alert_n,
  output logic ara_respond,
  output logic ara_take
);

  logic alert_q;
  logic alert_d;

  always_comb begin
    alert_d = status_q & ~mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_q <= 1'b0;
    else        alert_q <= alert_d;
  end

  assign alert_n     = ~alert_q;
  assign ara_respond = alert_q;
  // only a device that is holding the line takes part in the response exchange
  assign ara_take    = ara_ack & alert_q;

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |=> alert_n); // R4
  AST_ALERT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n |-> ($past(status_q) && !$past(mask_q))); // R1

endmodule

// File: rtl/tai_alert_ctrl.sv
module tai_alert_ctrl #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 8'h02,
  parameter logic [ADDR_W-1:0] ADDR_CFG  = 8'h09,
  parameter logic [ADDR_W-1:0] ADDR_LIM  = 8'h07,
  parameter logic [DATA_W-1:0] LIMIT_RST = 8'd70,
  parameter int MASK_BIT  = 7,
  parameter int STAT_BIT  = 4,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_temp,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ara_ack,
  output logic              alert_n,
  output logic              ara_respond
);

  localparam int SYNC_TOP = SYNC_LEN - 1;

  logic [SYNC_TOP:0] rst_sync_q;
  logic [SYNC_TOP:0] rst_sync_d;
  logic              rst_n_s;
  logic [DATA_W-1:0] limit_q;
  logic              mask_q;
  logic              stat_rd;
  logic              status_q;
  logic              ara_take;

  // reset: asserts at once, releases after SYNC_LEN clock edges
  generate
    if (SYNC_LEN > 1) begin : g_sync_chain
      assign rst_sync_d = {rst_sync_q[SYNC_TOP-1:0], 1'b1};
    end else begin : g_sync_single
      assign rst_sync_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= rst_sync_d;
  end

  assign rst_n_s = rst_sync_q[SYNC_TOP];

  tai_regfile #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .ADDR_STAT(ADDR_STAT),
    .ADDR_CFG (ADDR_CFG),
    .ADDR_LIM (ADDR_LIM),
    .LIMIT_RST(LIMIT_RST),
    .MASK_BIT (MASK_BIT),
    .STAT_BIT (STAT_BIT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .status_q (status_q),
    .ara_take (ara_take),
    .limit_q  (limit_q),
    .mask_q   (mask_q),
    .stat_rd  (stat_rd),
    .reg_rdata(reg_rdata)
  );

  tai_detect #(
    .DATA_W(DATA_W)
  ) u_detect (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .conv_done(conv_done),
    .conv_temp(conv_temp),
    .limit_q  (limit_q),
    .stat_rd  (stat_rd),
    .status_q (status_q)
  );

  tai_alert_drv u_drv (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .ara_ack    (ara_ack),
    .alert_n    (alert_n),
    .ara_respond(ara_respond),
    .ara_take   (ara_take)
  );

  logic cfg_wr_hit;
  logic stat_rd_hit;
  assign cfg_wr_hit  = reg_wr && (reg_addr == ADDR_CFG);
  assign stat_rd_hit = reg_rd && !reg_wr && (reg_addr == ADDR_STAT);

  AST_ARA_MASKS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ara_ack && !alert_n && !cfg_wr_hit) |=> mask_q); // R6
  AST_ARA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ara_ack && !alert_n && !cfg_wr_hit) |-> ##2 alert_n); // R6
  AST_ARA_SILENT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ara_ack && alert_n && !cfg_wr_hit && !stat_rd_hit) |=> $stable(mask_q)); // R8
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n_s)
    stat_rd_hit |-> ##2 alert_n); // R3

endmodule

// File: tb/tai_alert_ctrl_tb.sv
module tai_alert_ctrl_tb_top;

  localparam logic [7:0] A_STAT = 8'h02;
  localparam logic [7:0] A_CFG  = 8'h09;
  localparam logic [7:0] A_LIM  = 8'h07;

  localparam logic [2:0] OP_CONV = 3'd0;
  localparam logic [2:0] OP_WR   = 3'd1;
  localparam logic [2:0] OP_RD   = 3'd2;
  localparam logic [2:0] OP_ARA  = 3'd3;

  localparam int NVEC = 20;
  // {op, data_or_temp, addr, expected alert_n, expected read data}
  localparam logic [27:0] VEC [NVEC] = '{
    {OP_CONV, 8'd50,  8'h00,  1'b1, 8'h00}, // R2 below limit
    {OP_CONV, 8'd70,  8'h00,  1'b1, 8'h00}, // R2 equal to limit
    {OP_CONV, 8'd71,  8'h00,  1'b0, 8'h00}, // R2 R1 above limit
    {OP_CONV, 8'd20,  8'h00,  1'b0, 8'h00}, // R9 sticky
    {OP_ARA,  8'h00,  8'h00,  1'b1, 8'h00}, // R6 release
    {OP_RD,   8'h00,  A_CFG,  1'b1, 8'h80}, // R7 R5 mask set
    {OP_WR,   8'h00,  A_CFG,  1'b0, 8'h00}, // R6 status kept, R5 unmask
    {OP_RD,   8'h00,  A_STAT, 1'b1, 8'h10}, // R3
    {OP_CONV, 8'd100, 8'h00,  1'b1, 8'h00}, // R4 masked
    {OP_RD,   8'h00,  A_STAT, 1'b1, 8'h10}, // R4 flag still set
    {OP_WR,   8'h00,  A_CFG,  1'b1, 8'h00}, // R3 flag cleared
    {OP_ARA,  8'h00,  8'h00,  1'b1, 8'h00}, // R8 not asserting
    {OP_RD,   8'h00,  A_CFG,  1'b1, 8'h00}, // R8 mask untouched
    {OP_WR,   8'hF6,  A_LIM,  1'b1, 8'h00}, // R10 limit -10
    {OP_CONV, 8'hF5,  8'h00,  1'b1, 8'h00}, // R2 -11 below
    {OP_CONV, 8'h05,  8'h00,  1'b0, 8'h00}, // R2 signed compare
    {OP_RD,   8'h00,  A_LIM,  1'b0, 8'hF6}, // R10 limit readback
    {OP_WR,   8'hFF,  A_CFG,  1'b1, 8'h00}, // R5 mask by write
    {OP_RD,   8'h00,  A_CFG,  1'b1, 8'h80}, // R5 other bits zero
    {OP_WR,   8'h00,  A_CFG,  1'b0, 8'h00}  // R7 cleared only by write
  };

  logic       clk;
  logic       rst_n;
  logic       conv_done;
  logic [7:0] conv_temp;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       ara_ack;
  logic       alert_n;
  logic       ara_respond;

  int checks;
  int fails;
  logic [7:0] rd_cap;

  tai_alert_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .conv_temp  (conv_temp),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ara_ack    (ara_ack),
    .alert_n    (alert_n),
    .ara_respond(ara_respond)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    conv_done = 1'b0;
    reg_wr    = 1'b0;
    reg_rd    = 1'b0;
    ara_ack   = 1'b0;
  endtask

  // one strobe, then one extra cycle so the registered alert has settled
  task automatic step(input logic [2:0] op, input logic [7:0] d, input logic [7:0] a);
    @(negedge clk);
    reg_addr = a;
    case (op)
      OP_CONV: begin conv_done = 1'b1; conv_temp = d; end
      OP_WR:   begin reg_wr = 1'b1; reg_wdata = d; end
      OP_RD:   reg_rd = 1'b1;
      default: ara_ack = 1'b1;
    endcase
    #2 rd_cap = reg_rdata;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
  endtask

  task automatic check_line(input string req, input logic exp_n);
    check(req, {7'd0, alert_n}, {7'd0, exp_n});
    check("R1 ara_respond", {7'd0, ara_respond}, {7'd0, ~alert_n});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n  = 1'b0;
    idle_inputs();
    conv_temp = '0;
    reg_addr  = '0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    check_line("R10 alert in reset", 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state through the register port
    step(OP_RD, 8'h00, A_LIM);
    check("R10 limit reset", rd_cap, 8'h46);
    step(OP_RD, 8'h00, A_CFG);
    check("R10 mask reset", rd_cap, 8'h00);
    step(OP_RD, 8'h00, A_STAT);
    check("R10 status reset", rd_cap, 8'h00);
    step(OP_WR, 8'h00, A_CFG);
    check_line("R10 alert idle", 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][27:25], VEC[i][24:17], VEC[i][16:9]);
      check_line("R1 vector alert_n", VEC[i][8]);
      if (VEC[i][27:25] == OP_RD)
        check("R3 R5 vector rdata", rd_cap, VEC[i][7:0]);
    end

    // R11: over-limit conversion and status read in one cycle
    @(negedge clk);
    conv_done = 1'b1; conv_temp = 8'h05;
    reg_rd = 1'b1; reg_addr = A_STAT;
    #2 rd_cap = reg_rdata;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    check("R11 read before clear", rd_cap, 8'h10);
    check_line("R11 masked after read", 1'b1);
    step(OP_WR, 8'h00, A_CFG);
    check_line("R11 flag survived", 1'b0);

    // R2: reading without the strobe is ignored
    step(OP_RD, 8'h00, A_STAT);
    step(OP_WR, 8'h00, A_CFG);
    @(negedge clk);
    conv_temp = 8'h7F;
    repeat (3) @(negedge clk);
    check_line("R2 no strobe no alert", 1'b1);
    step(OP_RD, 8'h00, A_STAT);
    check("R2 no strobe status", rd_cap, 8'h00);

    // R10: mid-run reset after changing limit and mask
    step(OP_WR, 8'h10, A_LIM);
    step(OP_WR, 8'h80, A_CFG);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(OP_RD, 8'h00, A_LIM);
    check("R10 limit after reset", rd_cap, 8'h46);
    step(OP_RD, 8'h00, A_CFG);
    check("R10 mask after reset", rd_cap, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule